// File: doc/BRIEF.md
# ECC Error Capture Register

This block sits beside the SECDED checker on a memory read path and records the first ECC event it is told about. Each cycle the checker may pulse a corrected-error strobe, an uncorrectable-error strobe, or both. With each strobe it presents the access address and the 8-bit syndrome. The block keeps one 32-bit word that software reads and writes through a plain write-enable / write-data / read-data port. That word holds three control bits, the upper address bits and syndrome of the logged event, and two sticky type flags.

Once a flag is set, the log is frozen: later events change neither the address, the syndrome nor the flags. Software releases the log by writing 1 to the set flag, and the next event is then logged. Corrected errors can raise a level interrupt, and uncorrectable errors can raise a level system-error request; each has its own enable. Independently of the log, every corrected read can request a write-back of the repaired data to the failing address, unless scrubbing has been switched off.

The word layout, with bit 31 as the most significant bit:

| Bits | Access | Meaning |
|------|--------|---------|
| 31 | read/write | scrub-off |
| 30:12 | read-only | failing address bits 31:13 |
| 11:4 | read-only | syndrome |
| 3 | read/write | uncorrectable-error request enable |
| 2 | read/write | corrected-error interrupt enable |
| 1 | write-1-to-clear | uncorrectable flag |
| 0 | write-1-to-clear | corrected flag |

Top module: `ecc_err_log`

## Requirements
- R1: After reset, every bit of the status word reads 0, and `scrub_req`, `irq_ce` and `serr_ue` are low.
- R2: A write stores `reg_wdata` bits 31, 3 and 2 into the scrub-off bit and the two enable bits. Write-data bits 30:4 have no effect on what is read back.
- R3: When no flag is set and an error strobe arrives, the next cycle reads back address bits 31:13 in bits 30:12 and the syndrome in bits 11:4. It also reads back exactly one flag: bit 0 for a corrected error or bit 1 for an uncorrectable error.
- R4: While either flag is set, further strobes of either kind leave bits 30:0 of the word unchanged, apart from what software writes.
- R5: If both strobes arrive in the same cycle on an empty log, bit 1 is set and bit 0 stays 0. That event does not request a scrub.
- R6: Writing 1 to bit 0 or bit 1 clears that flag, and writing 0 leaves the flag as it is. Clearing a flag leaves the address and syndrome fields as they were.
- R7: After a flag has been cleared, the next error strobe is logged as in R3.
- R8: `irq_ce` is high exactly while bits 0 and 2 are both set. `serr_ue` is high exactly while bits 1 and 3 are both set.
- R9: With bit 31 at 0, a corrected-only strobe gives a one-cycle `scrub_req` in the next cycle, with that strobe's full address on `scrub_addr`. This happens even when the log is already full.
- R10: With bit 31 at 1, corrected strobes never raise `scrub_req`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ce_strobe | input | 1 | Corrected single-bit error seen this cycle |
| ue_strobe | input | 1 | Uncorrectable multi-bit error seen this cycle |
| err_addr | input | 32 | Address of the access that raised the strobe |
| err_syn | input | 8 | Syndrome of the access that raised the strobe |
| reg_wr_en | input | 1 | Write strobe for the status word |
| reg_wdata | input | 32 | Write data for the status word |
| reg_rdata | output | 32 | Current status word |
| scrub_req | output | 1 | One-cycle write-back request for a corrected read |
| scrub_addr | output | 32 | Address to write back, valid with `scrub_req` |
| irq_ce | output | 1 | Corrected-error interrupt, level |
| serr_ue | output | 1 | Uncorrectable-error system request, level |

## Verification
The bench builds the block with its default parameters. These are a 32-bit address, an 8-bit syndrome, a 19-bit kept address field and a two-stage reset synchronizer, so the word is exactly 32 bits wide. With that layout the bench's behavioural model can compare every field, every cycle. A directed sequence covers:
- an empty log, a full log, a flag clear followed by a new capture, and simultaneous strobes;
- each enable turned on and off;
- scrubbing with the log full and with scrubbing disabled.

A long random phase then mixes writes with strobes, including writes that clear a flag in the same cycle as a strobe arrives.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;
  parameter int unsigned ECC_ADDR_W = 32;
  parameter int unsigned ECC_SYN_W  = 8;
  parameter int unsigned ECC_KEEP_W = 19;

  // Kind of error event seen in one cycle, after arbitration of the strobes
  typedef enum logic [1:0] {
    EV_NONE = 2'd0,
    EV_CE   = 2'd1,
    EV_UE   = 2'd2
  } ecc_ev_e;
endpackage

// File: rtl/ecc_log_rst_sync.sv
module ecc_log_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= 1'b1;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/ecc_log_event.sv
module ecc_log_event
  import ecc_log_pkg::*;
(
  input  logic    ce_strobe,
  input  logic    ue_strobe,
  output ecc_ev_e ev
);
  // Uncorrectable wins when both strobes coincide
  always_comb begin
    if (ue_strobe)      ev = EV_UE;
    else if (ce_strobe) ev = EV_CE;
    else                ev = EV_NONE;
  end
endmodule

// File: rtl/ecc_log_regs.sv
module ecc_log_regs
  import ecc_log_pkg::*;
#(
  parameter int unsigned ADDR_W = ECC_ADDR_W,
  parameter int unsigned SYN_W  = ECC_SYN_W,
  parameter int unsigned KEEP_W = ECC_KEEP_W,
  parameter int unsigned WORD_W = 1 + KEEP_W + SYN_W + 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ecc_ev_e           ev,
  input  logic [ADDR_W-1:0] err_addr,
  input  logic [SYN_W-1:0]  err_syn,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata,
  output logic              scrub_off,
  output logic              ce_en,
  output logic              ue_en,
  output logic              st_ce,
  output logic              st_ue
);
  localparam int unsigned POS_OFF = WORD_W - 1;
  localparam int unsigned SYN_LO  = 4;
  localparam int unsigned ADDR_HI = WORD_W - 2;
  localparam int unsigned POS_UEN = 3;
  localparam int unsigned POS_CEN = 2;
  localparam int unsigned POS_SUE = 1;
  localparam int unsigned POS_SCE = 0;

  logic              off_q, off_d;
  logic              uen_q, uen_d;
  logic              cen_q, cen_d;
  logic              sue_q, sue_d;
  logic              sce_q, sce_d;
  logic [KEEP_W-1:0] addr_q, addr_d;
  logic [SYN_W-1:0]  syn_q, syn_d;
  logic              log_full;
  logic              cap_en;
  logic              st_en;
  logic              clr_any;

  // Next-state logic
  always_comb begin
    log_full = sue_q | sce_q;
    cap_en   = !log_full && (ev != EV_NONE);
    clr_any  = wr_en && (wdata[POS_SUE] || wdata[POS_SCE]);
    st_en    = wr_en | cap_en;
    off_d    = wdata[POS_OFF];
    uen_d    = wdata[POS_UEN];
    cen_d    = wdata[POS_CEN];
    addr_d   = err_addr[ADDR_W-1 -: KEEP_W];
    syn_d    = err_syn;
    sue_d    = sue_q & ~(wr_en & wdata[POS_SUE]);
    sce_d    = sce_q & ~(wr_en & wdata[POS_SCE]);
    if (cap_en) begin
      sue_d = (ev == EV_UE);
      sce_d = (ev == EV_CE);
    end
  end

  // Control bits, enabled by a write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q <= 1'b0;
      uen_q <= 1'b0;
      cen_q <= 1'b0;
    end else if (wr_en) begin
      off_q <= off_d;
      uen_q <= uen_d;
      cen_q <= cen_d;
    end
  end

  // Status flags
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sue_q <= 1'b0;
      sce_q <= 1'b0;
    end else if (st_en) begin
      sue_q <= sue_d;
      sce_q <= sce_d;
    end
  end

  // Captured fields, enabled only on a logged event
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      syn_q  <= '0;
    end else if (cap_en) begin
      addr_q <= addr_d;
      syn_q  <= syn_d;
    end
  end

  assign rdata     = {off_q, addr_q, syn_q, uen_q, cen_q, sue_q, sce_q};
  assign scrub_off = off_q;
  assign ce_en     = cen_q;
  assign ue_en     = uen_q;
  assign st_ce     = sce_q;
  assign st_ue     = sue_q;

  logic unused_bits;
  assign unused_bits = ^{wdata[ADDR_HI:SYN_LO], err_addr[ADDR_W-KEEP_W-1:0]};

  AST_ONE_TYPE: assert property (@(posedge clk) disable iff (!rst_n)
    !(sce_q && sue_q)); // R3

  AST_HOLD_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (log_full && !clr_any) |=> ($stable(addr_q) && $stable(syn_q) &&
                                $stable(sue_q) && $stable(sce_q))); // R4

  AST_UE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (!log_full && ev == EV_UE) |=> (sue_q && !sce_q)); // R5

  AST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (!log_full && ev != EV_NONE) |=> (syn_q == $past(err_syn))); // R7
endmodule

// File: rtl/ecc_log_out.sv
module ecc_log_out
  import ecc_log_pkg::*;
#(
  parameter int unsigned ADDR_W = ECC_ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ecc_ev_e           ev,
  input  logic [ADDR_W-1:0] err_addr,
  input  logic              scrub_off,
  input  logic              ce_en,
  input  logic              ue_en,
  input  logic              st_ce,
  input  logic              st_ue,
  output logic              scrub_req,
  output logic [ADDR_W-1:0] scrub_addr,
  output logic              irq_ce,
  output logic              serr_ue
);
  logic              fire;
  logic              req_q, req_d;
  logic [ADDR_W-1:0] saddr_q, saddr_d;

  always_comb begin
    fire    = (ev == EV_CE) && !scrub_off;
    req_d   = fire;
    saddr_d = err_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    saddr_q <= '0;
    else if (fire) saddr_q <= saddr_d;
  end

  assign scrub_req  = req_q;
  assign scrub_addr = saddr_q;
  assign irq_ce     = st_ce & ce_en;
  assign serr_ue    = st_ue & ue_en;

  AST_SCRUB_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == EV_CE && !scrub_off) |=> (scrub_req && scrub_addr == $past(err_addr))); // R9

  AST_NO_SCRUB_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == EV_CE && scrub_off) |=> !scrub_req); // R10

  AST_NO_SCRUB_UE: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == EV_UE) |=> !scrub_req); // R5
endmodule

// File: rtl/ecc_err_log.sv
module ecc_err_log
  import ecc_log_pkg::*;
#(
  parameter int unsigned ADDR_W     = ECC_ADDR_W,
  parameter int unsigned SYN_W      = ECC_SYN_W,
  parameter int unsigned KEEP_W     = ECC_KEEP_W,
  parameter int unsigned WORD_W     = 1 + KEEP_W + SYN_W + 4,
  parameter int unsigned RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_strobe,
  input  logic              ue_strobe,
  input  logic [ADDR_W-1:0] err_addr,
  input  logic [SYN_W-1:0]  err_syn,
  input  logic              reg_wr_en,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  output logic              scrub_req,
  output logic [ADDR_W-1:0] scrub_addr,
  output logic              irq_ce,
  output logic              serr_ue
);
  logic    rst_n_i;
  ecc_ev_e ev;
  logic    scrub_off, ce_en, ue_en, st_ce, st_ue;

  ecc_log_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  ecc_log_event u_ev (
    .ce_strobe (ce_strobe),
    .ue_strobe (ue_strobe),
    .ev        (ev)
  );

  ecc_log_regs #(
    .ADDR_W (ADDR_W),
    .SYN_W  (SYN_W),
    .KEEP_W (KEEP_W),
    .WORD_W (WORD_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .ev        (ev),
    .err_addr  (err_addr),
    .err_syn   (err_syn),
    .wr_en     (reg_wr_en),
    .wdata     (reg_wdata),
    .rdata     (reg_rdata),
    .scrub_off (scrub_off),
    .ce_en     (ce_en),
    .ue_en     (ue_en),
    .st_ce     (st_ce),
    .st_ue     (st_ue)
  );

  ecc_log_out #(.ADDR_W(ADDR_W)) u_out (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .ev         (ev),
    .err_addr   (err_addr),
    .scrub_off  (scrub_off),
    .ce_en      (ce_en),
    .ue_en      (ue_en),
    .st_ce      (st_ce),
    .st_ue      (st_ue),
    .scrub_req  (scrub_req),
    .scrub_addr (scrub_addr),
    .irq_ce     (irq_ce),
    .serr_ue    (serr_ue)
  );

  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n_i)
    irq_ce |-> (reg_rdata[0] && reg_rdata[2])); // R8

  AST_SERR_LEVEL: assert property (@(posedge clk) disable iff (!rst_n_i)
    serr_ue |-> (reg_rdata[1] && reg_rdata[3])); // R8
endmodule

// File: tb/ecc_err_log_tb_top.sv
module ecc_err_log_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ce_strobe, ue_strobe;
  logic [31:0] err_addr;
  logic [7:0]  err_syn;
  logic        reg_wr_en;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        scrub_req;
  logic [31:0] scrub_addr;
  logic        irq_ce, serr_ue;

  int n_chk  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  ecc_err_log dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .ce_strobe  (ce_strobe),
    .ue_strobe  (ue_strobe),
    .err_addr   (err_addr),
    .err_syn    (err_syn),
    .reg_wr_en  (reg_wr_en),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .scrub_req  (scrub_req),
    .scrub_addr (scrub_addr),
    .irq_ce     (irq_ce),
    .serr_ue    (serr_ue)
  );

  // Behavioural reference model
  int          m_cnt;
  bit          m_off, m_uen, m_cen, m_sue, m_sce, m_scrub;
  bit [18:0]   m_addr;
  bit [7:0]    m_syn;
  bit [31:0]   m_saddr;

  always @(posedge clk) begin
    if (rst_n !== 1'b1 || m_cnt < 2) begin
      if (rst_n !== 1'b1) m_cnt = 0;
      else                m_cnt = m_cnt + 1;
      m_off = 0; m_uen = 0; m_cen = 0; m_sue = 0; m_sce = 0; m_scrub = 0;
      m_addr = 0; m_syn = 0; m_saddr = 0;
    end else begin
      int  kind;
      bit  full;
      kind = ue_strobe ? 2 : (ce_strobe ? 1 : 0);
      full = m_sue || m_sce;
      m_scrub = (kind == 1) && !m_off;
      if (m_scrub) m_saddr = err_addr;
      if (reg_wr_en) begin
        m_off = reg_wdata[31];
        m_uen = reg_wdata[3];
        m_cen = reg_wdata[2];
        if (reg_wdata[1]) m_sue = 0;
        if (reg_wdata[0]) m_sce = 0;
      end
      if (!full && kind != 0) begin
        m_sue  = (kind == 2);
        m_sce  = (kind == 1);
        m_addr = err_addr[31:13];
        m_syn  = err_syn;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Cycle-by-cycle comparison against the model, away from the rising edge
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      chk("R2 control bits", {29'd0, reg_rdata[31], reg_rdata[3:2]}, {29'd0, m_off, m_uen, m_cen});
      chk("R4 address field", {13'd0, reg_rdata[30:12]}, {13'd0, m_addr});
      chk("R4 syndrome field", {24'd0, reg_rdata[11:4]}, {24'd0, m_syn});
      chk("R6 status flags", {30'd0, reg_rdata[1:0]}, {30'd0, m_sue, m_sce});
      chk("R8 irq_ce", {31'd0, irq_ce}, {31'd0, m_sce & m_cen});
      chk("R8 serr_ue", {31'd0, serr_ue}, {31'd0, m_sue & m_uen});
      chk("R9 scrub_req", {31'd0, scrub_req}, {31'd0, m_scrub});
      if (m_scrub) chk("R9 scrub_addr", scrub_addr, m_saddr);
    end
  end

  task automatic cyc(input bit ce, input bit ue, input logic [31:0] a, input logic [7:0] s,
                     input bit wr, input logic [31:0] wd);
    @(negedge clk);
    ce_strobe = ce; ue_strobe = ue; err_addr = a; err_syn = s;
    reg_wr_en = wr; reg_wdata = wd;
  endtask

  task automatic after_edge();
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] a1, a3, a4, a5, a6;
    logic [7:0]  s1, s4, s5, s6;
    a1 = 32'hDEAD_BEEF; s1 = 8'h5A;
    a3 = 32'h1234_5678;
    a4 = 32'hF00D_2000; s4 = 8'hC3;
    a5 = 32'h0BAD_F00D; s5 = 8'h81;
    a6 = 32'h7777_E000; s6 = 8'h3C;
    m_cnt = 0;
    rst_n = 1'b0;
    ce_strobe = 0; ue_strobe = 0; err_addr = 0; err_syn = 0; reg_wr_en = 0; reg_wdata = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset word", reg_rdata, 32'h0);
    chk("R1 reset outputs", {29'd0, scrub_req, irq_ce, serr_ue}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2: control bits written, read-only bits ignored
    cyc(0, 0, 0, 0, 1, 32'hFFFF_FFFC);
    after_edge();
    chk("R2 write readback", reg_rdata, 32'h8000_000C);
    cyc(0, 0, 0, 0, 1, 32'h0000_000C);
    after_edge();
    chk("R2 scrub-off cleared", reg_rdata, 32'h0000_000C);

    // R3: first corrected error logged; R9 scrub pulse; R8 interrupt
    cyc(1, 0, a1, s1, 0, 0);
    after_edge();
    chk("R3 corrected capture", reg_rdata, {1'b0, a1[31:13], s1, 2'b11, 2'b01});
    chk("R8 irq_ce on", {31'd0, irq_ce}, 32'd1);
    chk("R9 scrub pulse", {31'd0, scrub_req}, 32'd1);
    chk("R9 scrub address", scrub_addr, a1);
    cyc(0, 0, 0, 0, 0, 0);
    after_edge();
    chk("R9 one-cycle pulse", {31'd0, scrub_req}, 32'd0);

    // R4: full log ignores an uncorrectable and a corrected event
    cyc(0, 1, 32'hAAAA_AAAA, 8'hFF, 0, 0);
    after_edge();
    chk("R4 ue ignored when full", reg_rdata, {1'b0, a1[31:13], s1, 2'b11, 2'b01});
    chk("R4 serr stays low", {31'd0, serr_ue}, 32'd0);
    cyc(1, 0, a3, 8'h11, 0, 0);
    after_edge();
    chk("R4 ce ignored when full", reg_rdata, {1'b0, a1[31:13], s1, 2'b11, 2'b01});
    chk("R9 scrub while full", {31'd0, scrub_req}, 32'd1);
    chk("R9 scrub address while full", scrub_addr, a3);

    // R6: write-1 clear keeps fields
    cyc(0, 0, 0, 0, 1, 32'h0000_000D);
    after_edge();
    chk("R6 clear corrected flag", reg_rdata, {1'b0, a1[31:13], s1, 2'b11, 2'b00});
    chk("R8 irq_ce drops", {31'd0, irq_ce}, 32'd0);

    // R5: simultaneous strobes
    cyc(1, 1, a4, s4, 0, 0);
    after_edge();
    chk("R5 both strobes log ue", reg_rdata, {1'b0, a4[31:13], s4, 2'b11, 2'b10});
    chk("R5 no scrub on ue", {31'd0, scrub_req}, 32'd0);
    chk("R8 serr_ue on", {31'd0, serr_ue}, 32'd1);

    // R6: writing 0 to flags leaves them
    cyc(0, 0, 0, 0, 1, 32'h0000_000C);
    after_edge();
    chk("R6 zero write keeps flag", reg_rdata, {1'b0, a4[31:13], s4, 2'b11, 2'b10});

    // R10 with R7: disable scrub, clear, then a new corrected error
    cyc(0, 0, 0, 0, 1, 32'h8000_000E);
    after_edge();
    chk("R6 clear ue flag", reg_rdata, {1'b1, a4[31:13], s4, 2'b11, 2'b00});
    cyc(1, 0, a5, s5, 0, 0);
    after_edge();
    chk("R7 capture after clear", reg_rdata, {1'b1, a5[31:13], s5, 2'b11, 2'b01});
    chk("R10 no scrub when off", {31'd0, scrub_req}, 32'd0);

    // R8: interrupt enable off
    cyc(0, 0, 0, 0, 1, 32'h8000_0001);
    after_edge();
    chk("R6 clear with enables off", reg_rdata, {1'b1, a5[31:13], s5, 2'b00, 2'b00});
    cyc(1, 0, a6, s6, 0, 0);
    after_edge();
    chk("R7 second capture", reg_rdata, {1'b1, a6[31:13], s6, 2'b00, 2'b01});
    chk("R8 irq_ce gated by enable", {31'd0, irq_ce}, 32'd0);

    cyc(0, 0, 0, 0, 1, 32'h0000_0003);
    for (int i = 0; i < 3000; i++) begin
      cyc(($urandom % 4) == 0, ($urandom % 8) == 0, $urandom, 8'($urandom),
          ($urandom % 6) == 0, $urandom);
    end
    cyc(0, 0, 0, 0, 0, 0);
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule